// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a watchdog peripheral that sits on a simple APB-style register bus. A down-counter runs from a programmable reload value. The first time it expires, the block raises an interrupt and starts counting again. If software has not cleared that interrupt by the next expiry, the block raises a system reset request, provided reset generation is enabled. Software keeps the system alive by writing the clear register before the counter runs out. The current count can be read back at any time to see how many ticks remain.

All configuration registers are protected against stray writes. Writes to the reload, control and clear registers are dropped unless the lock register has first been written with the 32-bit key 0x1ACCE551. Writing any other value to the lock register protects the registers again. Bus accesses complete in a single access phase: a write takes effect at the clock edge where `psel`, `penable` and `pwrite` are all high. Read data is combinational from `paddr`.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the lock register (0xC00) reads 1, the reload register (0x000) reads all ones of the counter width, control (0x008) reads 0, status (0x014) reads 0, and `irq` and `rst_req` are low.
- R2: While locked, writes to reload, control and clear have no effect on any register, count, `irq` or `rst_req`. Reads still return the register contents.
- R3: Writing 0x1ACCE551 to 0xC00 unlocks the block, and the lock register then reads 0. Writing any other value locks it, and it then reads 1.
- R4: An unlocked write to 0x000 stores the new reload value and also loads it into the counter at once. The count is read at 0x004, zero-extended.
- R5: While control bit 1 is set, the count drops by one per clock. In the clock after it reads 0 it expires and reloads, so one period is reload+1 clocks.
- R6: The first expiry sets the pending flag. `irq` follows the flag, and status reads 1 while it is set.
- R7: Any unlocked write to 0x00C clears the pending flag and reloads the counter from the reload register.
- R8: An expiry while the flag is already pending raises `rst_req` only when control bit 0 is 1. With bit 0 at 0, the flag simply stays pending.
- R9: While control bit 1 is 0, the count holds its value and no expiry, interrupt or reset occurs.
- R10: Once raised, `rst_req` stays high until the block reset, and clearing the interrupt does not lower it.
- R11: Control reads back only bits 1:0. Bits 31:2 read as zero whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| irq | output | 1 | Timeout interrupt, high while pending |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with a counter width of 16. This makes the reset-value readback of the reload register (0xFFFF) quick to check, while the width of the bus and of the key compare stays at 32. The counter is then run from a reload value of 6, so that both one-period and two-period expiries fit in a few dozen clocks. These short periods let the bench sample the exact clock of each expiry. It checks that the interrupt appears after reload+1 clocks and that the reset request appears after twice that, and not one clock earlier.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_LOAD   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'hC00;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    // bit 1 = run (counter and interrupt), bit 0 = reset enable
    typedef struct packed {
        logic run;
        logic rst_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_LOAD, SEL_COUNT, SEL_CTRL, SEL_CLEAR, SEL_STATUS, SEL_LOCK
    } reg_sel_e;

    typedef struct packed {
        logic load_wr;
        logic clear_wr;
    } cmd_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LOAD:   return SEL_LOAD;
            OFS_COUNT:  return SEL_COUNT;
            OFS_CTRL:   return SEL_CTRL;
            OFS_CLEAR:  return SEL_CLEAR;
            OFS_STATUS: return SEL_STATUS;
            OFS_LOCK:   return SEL_LOCK;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [ADDR_W-1:0]         paddr,
    input  logic [BUS_W-1:0]          pwdata,
    input  logic [CNT_W-1:0]          count,
    input  logic                      pending,
    output logic [BUS_W-1:0]          prdata,
    output ctrl_t                     ctrl,
    output cmd_t                      cmd,
    output logic [CNT_W-1:0]          reload_val
);
    logic             locked_q;
    logic [CNT_W-1:0] load_q;
    ctrl_t            ctrl_q;
    logic             wr;
    reg_sel_e         sel;

    assign wr  = psel && penable && pwrite;
    assign sel = decode_addr(paddr);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
            load_q   <= '1;
            ctrl_q   <= '0;
        end else if (wr) begin
            if (sel == SEL_LOCK) begin
                locked_q <= (pwdata != UNLOCK_KEY);
            end else if (!locked_q) begin
                if (sel == SEL_LOAD) load_q <= pwdata[CNT_W-1:0];
                if (sel == SEL_CTRL) ctrl_q <= ctrl_t'(pwdata[1:0]);
            end
        end
    end

    always_comb begin
        cmd.load_wr  = wr && !locked_q && (sel == SEL_LOAD);
        cmd.clear_wr = wr && !locked_q && (sel == SEL_CLEAR);
        reload_val   = cmd.load_wr ? pwdata[CNT_W-1:0] : load_q;
    end

    assign ctrl = ctrl_q;

    always_comb begin
        prdata = '0;
        case (sel)
            SEL_LOAD:   prdata = BUS_W'(load_q);
            SEL_COUNT:  prdata = BUS_W'(count);
            SEL_CTRL:   prdata = BUS_W'(ctrl_q);
            SEL_STATUS: prdata = BUS_W'(pending);
            SEL_LOCK:   prdata = BUS_W'(locked_q);
            default:    prdata = '0;
        endcase
    end

    // R2
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && wr && sel != SEL_LOCK) |=> ($stable(load_q) && $stable(ctrl_q)));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign expire  = run && !reload && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (reload || expire) begin
            cnt_q <= reload_val;
        end else if (run) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;

    // R9
    halted_count_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/kwd_alarm.sv
module kwd_alarm (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clear,
    input  logic rst_en,
    output logic pending,
    output logic rst_req
);
    logic pend_q;
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            if (clear)       pend_q <= 1'b0;
            else if (expire) pend_q <= 1'b1;
            if (expire && pend_q && !clear && rst_en) req_q <= 1'b1;
        end
    end

    assign pending = pend_q;
    assign rst_req = req_q;

    // R10
    reset_request_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |=> req_q);

    // R8
    reset_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> ($past(pend_q) && $past(rst_en) && $past(expire)));

    // R6
    pending_from_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(expire));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [11:0]       paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t            ctrl;
    cmd_t             cmd;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             pending;

    kwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .count(count), .pending(pending),
        .prdata(prdata), .ctrl(ctrl), .cmd(cmd), .reload_val(reload_val)
    );

    kwd_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .run(ctrl.run),
        .reload(cmd.load_wr || cmd.clear_wr),
        .reload_val(reload_val), .count(count), .expire(expire)
    );

    kwd_alarm u_alarm (
        .clk(clk), .rst(rst), .expire(expire), .clear(cmd.clear_wr),
        .rst_en(ctrl.rst_en), .pending(pending), .rst_req(rst_req)
    );

    assign irq = pending;

    // R9
    no_expiry_when_halted_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !expire);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
    localparam int CW = 16;
    localparam logic [31:0] KEY = 32'h1ACC_E551;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq, rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    keyed_watchdog #(.CNT_W(CW)) i_keyed_watchdog (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(12'hC00, v); check("R1 lock after reset", v, 32'd1);
        rd(12'h000, v); check("R1 reload after reset", v, 32'h0000_FFFF);
        rd(12'h008, v); check("R1 ctrl after reset", v, 32'd0);
        rd(12'h014, v); check("R1 status after reset", v, 32'd0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 rst_req after reset", {31'd0, rst_req}, 32'd0);
    endtask

    task automatic t_locked_writes();
        logic [31:0] v;
        wr(12'h000, 32'd5);
        rd(12'h000, v); check("R2 locked reload write", v, 32'h0000_FFFF);
        wr(12'h008, 32'd3);
        rd(12'h008, v); check("R2 locked ctrl write", v, 32'd0);
    endtask

    task automatic t_unlock_and_load();
        logic [31:0] v;
        wr(12'hC00, KEY);
        rd(12'hC00, v); check("R3 lock after key", v, 32'd0);
        wr(12'h000, 32'd10);
        rd(12'h000, v); check("R4 reload readback", v, 32'd10);
        rd(12'h004, v); check("R4 count loaded at once", v, 32'd10);
        wr(12'hC00, 32'h1234_5678);
        rd(12'hC00, v); check("R3 lock after wrong value", v, 32'd1);
        wr(12'h008, 32'd2);
        rd(12'h008, v); check("R2 ctrl write after relock", v, 32'd0);
    endtask

    task automatic t_ctrl_reserved();
        logic [31:0] v;
        wr(12'hC00, KEY);
        wr(12'h008, 32'hFFFF_FFFC);
        rd(12'h008, v); check("R11 reserved ctrl bits", v, 32'd0);
        wr(12'h008, 32'hFFFF_FFFD);
        rd(12'h008, v); check("R11 ctrl keeps bits 1:0", v, 32'd1);
        wr(12'h008, 32'd0);
    endtask

    task automatic t_first_expiry();
        logic [31:0] v;
        wr(12'h000, 32'd6);
        wr(12'h008, 32'd2);
        repeat (3) @(negedge clk);
        rd(12'h004, v); check("R5 count after 3 clocks", v, 32'd3);
        repeat (3) @(negedge clk);
        rd(12'h004, v); check("R5 count at zero", v, 32'd0);
        check("R6 irq before expiry", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R6 irq at first expiry", {31'd0, irq}, 32'd1);
        rd(12'h014, v); check("R6 status pending", v, 32'd1);
        rd(12'h004, v); check("R5 reload after expiry", v, 32'd6);
    endtask

    task automatic t_clear_and_no_reset();
        logic [31:0] v;
        wr(12'h00C, 32'd0);
        check("R7 irq cleared", {31'd0, irq}, 32'd0);
        rd(12'h004, v); check("R7 count reloaded", v, 32'd6);
        repeat (7) @(negedge clk);
        check("R6 irq on next expiry", {31'd0, irq}, 32'd1);
        repeat (7) @(negedge clk);
        check("R8 no reset when disabled", {31'd0, rst_req}, 32'd0);
        check("R8 irq still pending", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_halt_and_locked_clear();
        logic [31:0] v, w;
        wr(12'h008, 32'd0);
        rd(12'h004, v);
        repeat (9) @(negedge clk);
        rd(12'h004, w); check("R9 count holds when stopped", w, v);
        wr(12'hC00, 32'd0);
        wr(12'h00C, 32'd1);
        check("R2 locked clear keeps irq", {31'd0, irq}, 32'd1);
        rd(12'h004, w); check("R2 locked clear keeps count", w, v);
        wr(12'hC00, KEY);
    endtask

    task automatic t_two_stage_reset();
        logic [31:0] v;
        wr(12'h00C, 32'd0);
        rd(12'h004, v); check("R7 count reloaded before arm", v, 32'd6);
        wr(12'h008, 32'd3);
        repeat (7) @(negedge clk);
        check("R6 irq at first stage", {31'd0, irq}, 32'd1);
        check("R8 no reset at first stage", {31'd0, rst_req}, 32'd0);
        repeat (6) @(negedge clk);
        check("R8 no reset one clock early", {31'd0, rst_req}, 32'd0);
        @(negedge clk);
        check("R8 reset at second expiry", {31'd0, rst_req}, 32'd1);
        wr(12'h00C, 32'd0);
        check("R10 reset stays after clear", {31'd0, rst_req}, 32'd1);
        check("R7 irq cleared after clear", {31'd0, irq}, 32'd0);
        do_reset();
        check("R10 reset request dropped by block reset", {31'd0, rst_req}, 32'd0);
        rd(12'hC00, v); check("R1 relocked by block reset", v, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset_state();
        t_locked_writes();
        t_unlock_and_load();
        t_ctrl_reserved();
        t_first_expiry();
        t_clear_and_no_reset();
        t_halt_and_locked_clear();
        t_two_stage_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule